// File: doc/BRIEF.md
# Guarded Transmit Byte Queue for a Two-Wire Serial Controller

This block holds the bytes that a two-wire serial controller is about to send, in order. The host pushes bytes with a write strobe. The bus engine works through them in two steps. It samples the byte at the head when it starts shifting it out. It retires that byte only after the byte has gone out completely. If the engine samples while the queue is empty, it receives an all-ones filler byte and an underflow flag is raised.

Some bus events make any queued data stale for the new transaction. When one of these events occurs, the queue empties itself and a lockout flag is set. While that flag is set, host writes are refused until firmware clears it. There are four slave-side events, and each has its own disable bit. The six error events always flush the queue and cannot be disabled.

The block also provides three more functions:
- A level-at-or-below-threshold interrupt.
- A software flush.
- A readiness output that the engine uses to decide whether to acknowledge a slave read request when clock stretching is off.

Top module: `twi_txq_guard`

## Requirements
- R1: Bytes leave in the order they were written. `head_data` shows the oldest byte, and that byte is removed only when `eng_sent` is high with the queue non-empty. `eng_sent` on an empty queue has no effect.
- R2: While the queue is empty, `head_data` is 8'hFF. An `eng_load` pulse on an empty queue while enabled sets `unf_flag`. The flag stays set until a `clr_unf` pulse clears it, and a new set in the same cycle wins over the clear.
- R3: The queue holds at most 8 bytes (`full` high at level 8). A write while full is dropped and leaves the contents unchanged.
- R4: Slave event bits are indexed as follows: bit0 general call match, bit1 own address match for write, bit2 own address match for read, bit3 NACK received as slave transmitter. An event bit whose matching `slv_dis` bit is 0 empties the queue and sets `lock_flag` on the next edge. With the disable bit at 1, that event has no effect.
- R5: Any bit of `err_ev` empties the queue and sets `lock_flag`, whatever the value of `slv_dis`. The bits are arbitration loss, timeout, master address NACK, master data NACK, start error and stop error.
- R6: While `lock_flag` is 1, host writes are ignored. A `clr_lock` pulse clears the flag for the following cycle. A flush event in the same cycle as `clr_lock` keeps the flag set.
- R7: When a host write coincides with a flushing event, the flush wins and the written byte is discarded.
- R8: While `enable` is 0, the queue is empty and writes and events have no effect, so `lock_flag` is not set. A `sw_flush` pulse empties the queue without setting `lock_flag`.
- R9: `thr_irq` is high exactly when `enable` is 1 and `level` is less than or equal to `thresh`.
- R10: `ack_rd` is 0 (answer NACK) when `stretch_dis` is 1 and the queue is empty. Otherwise it is 1.
- R11: A write and a retire in the same cycle keep the level unchanged and queue the new byte behind the remaining ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Peripheral enable; low keeps the queue empty |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| sw_flush | input | 1 | Software flush pulse |
| eng_load | input | 1 | Engine samples the head byte |
| eng_sent | input | 1 | Engine finished sending the head byte |
| slv_ev | input | 4 | Slave-side flush events (see R4 for bit order) |
| slv_dis | input | 4 | Per-event auto-flush disable |
| err_ev | input | 6 | Error events, always flushing |
| clr_lock | input | 1 | Clears the lockout flag |
| clr_unf | input | 1 | Clears the underflow flag |
| thresh | input | 4 | Level threshold for the interrupt |
| stretch_dis | input | 1 | Clock stretching disabled (slave preload mode) |
| head_data | output | 8 | Oldest byte, or 8'hFF when empty |
| level | output | 4 | Number of queued bytes |
| empty | output | 1 | Queue empty |
| full | output | 1 | Queue full |
| lock_flag | output | 1 | Host writes locked out after an auto-flush |
| unf_flag | output | 1 | Underflow recorded |
| thr_irq | output | 1 | Level at or below threshold |
| ack_rd | output | 1 | Acknowledge a slave read request |

## Verification
The hardest situation to reach is a flushing event that lands in the same cycle as something that would otherwise change the state:
- a host write (R7);
- a lock clear (R6).

A plain sequence of writes and events never lines these up. The stimulus therefore drives each pair in one cycle and observes `level` and `lock_flag` on the next cycle. The per-event disable is reached by walking every slave event bit twice: once masked, with data queued so that a wrongful flush would be visible, and once unmasked.

// File: rtl/twi_txq_pkg.sv
// Package: shared constants for the guarded transmit queue.
// Assumes slave event bit order is fixed by the bus engine that drives it.
package twi_txq_pkg;
    localparam int EV_GCALL    = 0;   // general call match
    localparam int EV_ADR_WR   = 1;   // own address, write
    localparam int EV_ADR_RD   = 2;   // own address, read
    localparam int EV_SLV_NACK = 3;   // NACK seen as slave transmitter
    localparam int N_SLV_EV    = 4;
    localparam int N_ERR_EV    = 6;
endpackage

// File: rtl/twi_txq_store.sv
// Module: circular byte storage with level tracking.
// Does: holds up to DEPTH bytes, presents the oldest, fills with all-ones
// when empty. Assumes flush has priority over push/pop; gates push on full
// and pop on empty itself.
module twi_txq_store #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVLW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            push,
    input  logic [DW-1:0]   wdata,
    input  logic            pop,
    output logic [DW-1:0]   head,
    output logic [LVLW-1:0] level,
    output logic            empty,
    output logic            full
);
    logic [DW-1:0]   mem [DEPTH];
    logic [PTRW-1:0] wr_ptr, rd_ptr;
    logic            push_ok, pop_ok;

    function automatic logic [PTRW-1:0] wrap_inc(input logic [PTRW-1:0] p);
        return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Qualify requests against occupancy and flush.
    always_comb begin
        empty   = (level == '0);
        full    = (level == LVLW'(DEPTH));
        push_ok = push && !full && !flush;
        pop_ok  = pop && !empty && !flush;
        head    = empty ? {DW{1'b1}} : mem[rd_ptr];
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wrap_inc(wr_ptr);
            if (pop_ok)  rd_ptr <= wrap_inc(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/twi_txq_lock.sv
// Module: auto-flush decision and lockout flag.
// Does: qualifies each slave event by its disable bit, adds the
// unmaskable errors, raises flush and lockout, and gates host writes.
// Assumes events are single-cycle pulses from the bus engine.
module twi_txq_lock #(
    parameter int N_SLV = 4,
    parameter int N_ERR = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             host_wr,
    input  logic             sw_flush,
    input  logic [N_SLV-1:0] slv_ev,
    input  logic [N_SLV-1:0] slv_dis,
    input  logic [N_ERR-1:0] err_ev,
    input  logic             clr_lock,
    output logic             flush,
    output logic             push_req,
    output logic             lock_flag
);
    logic [N_SLV-1:0] slv_hit;
    logic             auto_hit;

    // One qualifier per maskable event.
    for (genvar i = 0; i < N_SLV; i++) begin : g_qual
        assign slv_hit[i] = slv_ev[i] && !slv_dis[i];
    end

    // Combine event sources into flush and write gating.
    always_comb begin
        auto_hit = enable && ((|slv_hit) || (|err_ev));
        flush    = !enable || sw_flush || auto_hit;
        push_req = enable && host_wr && !lock_flag && !flush;
    end

    // Lockout flag: set by auto-flush, set beats firmware clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        lock_flag <= 1'b0;
        else if (auto_hit) lock_flag <= 1'b1;
        else if (clr_lock) lock_flag <= 1'b0;
    end
endmodule

// File: rtl/twi_txq_flags.sv
// Module: underflow flag, threshold interrupt and read-ready indication.
// Does: records engine loads from an empty queue, compares level to the
// threshold and decides the acknowledge of a slave read request.
module twi_txq_flags #(
    parameter int LVLW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            eng_load,
    input  logic            empty,
    input  logic            clr_unf,
    input  logic [LVLW-1:0] level,
    input  logic [LVLW-1:0] thresh,
    input  logic            stretch_dis,
    output logic            unf_flag,
    output logic            thr_irq,
    output logic            ack_rd
);
    logic unf_set;

    // Level comparison and preload readiness.
    always_comb begin
        unf_set = enable && eng_load && empty;
        thr_irq = enable && (level <= thresh);
        ack_rd  = !stretch_dis || !empty;
    end

    // Sticky underflow flag, set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       unf_flag <= 1'b0;
        else if (unf_set) unf_flag <= 1'b1;
        else if (clr_unf) unf_flag <= 1'b0;
    end
endmodule

// File: rtl/twi_txq_guard.sv
// Module: guarded transmit byte queue (top).
// Does: joins storage, flush/lockout control and status flags.
// Assumes all inputs are synchronous to clk.
module twi_txq_guard
    import twi_txq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int LVLW = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                host_wr,
    input  logic [DW-1:0]       host_wdata,
    input  logic                sw_flush,
    input  logic                eng_load,
    input  logic                eng_sent,
    input  logic [N_SLV_EV-1:0] slv_ev,
    input  logic [N_SLV_EV-1:0] slv_dis,
    input  logic [N_ERR_EV-1:0] err_ev,
    input  logic                clr_lock,
    input  logic                clr_unf,
    input  logic [LVLW-1:0]     thresh,
    input  logic                stretch_dis,
    output logic [DW-1:0]       head_data,
    output logic [LVLW-1:0]     level,
    output logic                empty,
    output logic                full,
    output logic                lock_flag,
    output logic                unf_flag,
    output logic                thr_irq,
    output logic                ack_rd
);
    logic flush, push_req;

    // Flush and lockout control.
    twi_txq_lock #(.N_SLV(N_SLV_EV), .N_ERR(N_ERR_EV)) u_lock (
        .clk(clk), .rst_n(rst_n), .enable(enable), .host_wr(host_wr),
        .sw_flush(sw_flush), .slv_ev(slv_ev), .slv_dis(slv_dis),
        .err_ev(err_ev), .clr_lock(clr_lock), .flush(flush),
        .push_req(push_req), .lock_flag(lock_flag)
    );

    // Byte storage.
    twi_txq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(push_req),
        .wdata(host_wdata), .pop(eng_sent), .head(head_data),
        .level(level), .empty(empty), .full(full)
    );

    // Status flags.
    twi_txq_flags #(.LVLW(LVLW)) u_flags (
        .clk(clk), .rst_n(rst_n), .enable(enable), .eng_load(eng_load),
        .empty(empty), .clr_unf(clr_unf), .level(level), .thresh(thresh),
        .stretch_dis(stretch_dis), .unf_flag(unf_flag), .thr_irq(thr_irq),
        .ack_rd(ack_rd)
    );
endmodule

// File: rtl/twi_txq_guard_chk.sv
// Checker: temporal properties of the guarded transmit queue, bound to top.
module twi_txq_guard_chk #(
    parameter int DEPTH  = 8,
    parameter int DW     = 8,
    parameter int N_ERR  = 6,
    localparam int LVLW  = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            enable,
    input logic            eng_load,
    input logic [N_ERR-1:0] err_ev,
    input logic [DW-1:0]   head_data,
    input logic [LVLW-1:0] level,
    input logic            empty,
    input logic            full,
    input logic            lock_flag,
    input logic            unf_flag
);
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (level <= LVLW'(DEPTH)) && (full == (level == LVLW'(DEPTH))));

    assert_fill_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> head_data == {DW{1'b1}});

    assert_unf_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && eng_load && empty) |=> unf_flag);

    assert_err_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (|err_ev)) |=> (level == '0) && lock_flag);

    assert_locked_no_grow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_flag |=> level <= $past(level));

    assert_disabled_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> empty);
endmodule

bind twi_txq_guard twi_txq_guard_chk #(.DEPTH(DEPTH), .DW(DW), .N_ERR(twi_txq_pkg::N_ERR_EV)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .eng_load(eng_load),
    .err_ev(err_ev), .head_data(head_data), .level(level), .empty(empty),
    .full(full), .lock_flag(lock_flag), .unf_flag(unf_flag)
);

// File: tb/twi_txq_guard_tb_top.sv
module twi_txq_guard_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0, host_wr = 1'b0, sw_flush = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       eng_load = 1'b0, eng_sent = 1'b0;
    logic [3:0] slv_ev = '0, slv_dis = '0;
    logic [5:0] err_ev = '0;
    logic       clr_lock = 1'b0, clr_unf = 1'b0, stretch_dis = 1'b0;
    logic [3:0] thresh = '0;
    logic [7:0] head_data;
    logic [3:0] level;
    logic       empty, full, lock_flag, unf_flag, thr_irq, ack_rd;
    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    twi_txq_guard dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .host_wr(host_wr),
        .host_wdata(host_wdata), .sw_flush(sw_flush), .eng_load(eng_load),
        .eng_sent(eng_sent), .slv_ev(slv_ev), .slv_dis(slv_dis), .err_ev(err_ev),
        .clr_lock(clr_lock), .clr_unf(clr_unf), .thresh(thresh),
        .stretch_dis(stretch_dis), .head_data(head_data), .level(level),
        .empty(empty), .full(full), .lock_flag(lock_flag), .unf_flag(unf_flag),
        .thr_irq(thr_irq), .ack_rd(ack_rd)
    );

    // Table: {wr, wdata, sent, exp_level, exp_head}
    localparam logic [21:0] VEC [10] = '{
        {1'b1, 8'hA1, 1'b0, 4'd1, 8'hA1},
        {1'b1, 8'hB2, 1'b0, 4'd2, 8'hA1},
        {1'b1, 8'hC3, 1'b1, 4'd2, 8'hB2},
        {1'b0, 8'h00, 1'b1, 4'd1, 8'hC3},
        {1'b0, 8'h00, 1'b1, 4'd0, 8'hFF},
        {1'b0, 8'h00, 1'b1, 4'd0, 8'hFF},
        {1'b1, 8'hD4, 1'b0, 4'd1, 8'hD4},
        {1'b1, 8'hE5, 1'b0, 4'd2, 8'hD4},
        {1'b0, 8'h00, 1'b1, 4'd1, 8'hE5},
        {1'b0, 8'h00, 1'b1, 4'd0, 8'hFF}
    };

    task automatic chk(input string tag, input int act, input int exp_v);
        n_tests++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp_v);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        host_wr = 0; sw_flush = 0; eng_load = 0; eng_sent = 0;
        slv_ev = '0; err_ev = '0; clr_lock = 0; clr_unf = 0;
    endtask

    task automatic wr(input logic [7:0] d);
        host_wr = 1; host_wdata = d; tick();
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog R1 act=hung exp=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        chk("reset level", int'(level), 0);
        chk("reset head R2", int'(head_data), 8'hFF);
        chk("reset flags", int'({lock_flag, unf_flag, thr_irq}), 0);
        enable = 1;

        // R1 and R11 table walk
        for (int k = 0; k < 10; k++) begin
            host_wr = VEC[k][21]; host_wdata = VEC[k][20:13]; eng_sent = VEC[k][12];
            tick();
            chk($sformatf("R1 vec%0d level", k), int'(level), int'(VEC[k][11:8]));
            chk($sformatf("R1 vec%0d head", k), int'(head_data), int'(VEC[k][7:0]));
        end

        // R3 full
        for (int k = 0; k < 9; k++) wr(8'h10 + 8'(k));
        chk("R3 level full", int'(level), 8);
        chk("R3 full flag", int'(full), 1);
        for (int k = 0; k < 8; k++) begin
            chk("R3 R1 order", int'(head_data), 8'h10 + k);
            eng_sent = 1; tick();
        end
        chk("R3 drained", int'(level), 0);

        // R2 underflow
        eng_load = 1; tick();
        chk("R2 unf set", int'(unf_flag), 1);
        chk("R2 filler", int'(head_data), 8'hFF);
        clr_unf = 1; tick();
        chk("R2 unf cleared", int'(unf_flag), 0);
        eng_load = 1; clr_unf = 1; tick();
        chk("R2 set beats clear", int'(unf_flag), 1);
        clr_unf = 1; tick();

        // R4 each slave event, masked then unmasked
        for (int i = 0; i < 4; i++) begin
            wr(8'h01); wr(8'h02);
            slv_dis = 4'(1 << i); slv_ev = 4'(1 << i); tick();
            chk($sformatf("R4 masked ev%0d level", i), int'(level), 2);
            chk($sformatf("R4 masked ev%0d lock", i), int'(lock_flag), 0);
            slv_dis = '0; slv_ev = 4'(1 << i); tick();
            chk($sformatf("R4 ev%0d flush", i), int'(level), 0);
            chk($sformatf("R4 ev%0d lock", i), int'(lock_flag), 1);
            wr(8'h33);
            chk("R6 write ignored while locked", int'(level), 0);
            clr_lock = 1; tick();
            chk("R6 lock cleared", int'(lock_flag), 0);
            wr(8'h44);
            chk("R6 write after clear", int'(level), 1);
            sw_flush = 1; tick();
            chk("R8 sw flush empties", int'(level), 0);
            chk("R8 sw flush no lock", int'(lock_flag), 0);
        end

        // R5 errors ignore disables
        slv_dis = 4'hF;
        for (int i = 0; i < 6; i++) begin
            wr(8'h5A);
            err_ev = 6'(1 << i); tick();
            chk($sformatf("R5 err%0d flush", i), int'(level), 0);
            chk($sformatf("R5 err%0d lock", i), int'(lock_flag), 1);
            clr_lock = 1; tick();
        end
        slv_dis = '0;

        // R6 set beats clear
        err_ev = 6'h01; clr_lock = 1; tick();
        chk("R6 set beats clear", int'(lock_flag), 1);
        clr_lock = 1; tick();

        // R7 write coinciding with flush event
        host_wr = 1; host_wdata = 8'h77; slv_ev = 4'h1; tick();
        chk("R7 write dropped", int'(level), 0);
        chk("R7 lock set", int'(lock_flag), 1);
        clr_lock = 1; tick();

        // R11 write and retire together
        wr(8'h55);
        host_wr = 1; host_wdata = 8'h66; eng_sent = 1; tick();
        chk("R11 level kept", int'(level), 1);
        chk("R11 head new", int'(head_data), 8'h66);

        // R10 preload readiness
        stretch_dis = 1;
        chk("R10 ack with data", int'(ack_rd), 1);
        eng_sent = 1; tick();
        chk("R10 nack empty", int'(ack_rd), 0);
        stretch_dis = 0; #1;
        chk("R10 ack stretching", int'(ack_rd), 1);

        // R9 threshold
        thresh = 4'd1; #1;
        chk("R9 level0", int'(thr_irq), 1);
        wr(8'h01);
        chk("R9 level1", int'(thr_irq), 1);
        wr(8'h02);
        chk("R9 level2", int'(thr_irq), 0);

        // R8 disabled
        enable = 0; tick();
        chk("R8 disabled empty", int'(level), 0);
        chk("R9 irq off when disabled", int'(thr_irq), 0);
        wr(8'h99);
        chk("R8 write no effect", int'(level), 0);
        err_ev = 6'h3F; slv_ev = 4'hF; tick();
        chk("R8 event no lock", int'(lock_flag), 0);
        enable = 1; tick();
        chk("R8 re-enabled empty", int'(level), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule